// File: doc/BRIEF.md
# Programmable-Limit Saturating Sample Adder

This block adds signed 16-bit sample streams and clamps each result between a lower and an upper bound that software can rewrite at any time. It holds three junctions. Two of them sit in front of a complex up-converter and sum the contributions of two oscillators, one junction for the in-phase path and one for the quadrature path. Both of those junctions read a single shared pair of bounds. The third junction sits in front of the DAC. It adds an offset stream to the up-converter's in-phase output and to the partner channel's quadrature output, and a two-bit enable register gates each of those two terms.

Every sum is formed in a wide accumulator, so no intermediate value can wrap. Each junction then compares the sum with its bounds and registers the clamped sample. The adder has one register stage. A write to a bound or to the enable register is registered, so it applies to the sample captured on the following clock edge.

Top module: `clamp_adder_bank`

## Requirements
- R1: When the lower bound is not above the upper bound, a junction output always lies within [lower, upper] of the bounds that were in force when its sample was captured.
- R2: After reset, every bound pair holds lower = -32767 and upper = +32767, so sums beyond full scale clamp to those values.
- R3: The sum is formed without intermediate overflow: for example, 30000 + 30000 + (-30000) produces 30000, and a true sum of -35000 clamps to the lower bound instead of wrapping.
- R4: The DAC junction output is the clamped sum of `dac_offset`, plus `dac_uc_i` when enable bit 0 is 1, plus `dac_partner_q` when enable bit 1 is 1.
- R5: After reset the enable register is 2'b01: the in-phase term is on and the partner quadrature term is off.
- R6: The in-phase and quadrature up-converter junctions both use the bound pair written through the `uc_*` ports. The DAC junction uses only the bound pair written through the `dac_*` bound ports.
- R7: If the lower bound is above the upper bound, the upper comparison wins: a sum greater than the upper bound yields the upper bound, and any other sum below the lower bound yields the lower bound.
- R8: A bound or enable write strobed at a clock edge does not affect the sample captured on that edge. It affects the sample captured on the next edge.
- R9: Latency is one clock. Inputs present at an edge appear at the outputs just after that edge, and all outputs are 0 during and after reset until the first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uc_i_a | input | 16 | In-phase sample of oscillator A (signed) |
| uc_i_b | input | 16 | In-phase sample of oscillator B (signed) |
| uc_q_a | input | 16 | Quadrature sample of oscillator A (signed) |
| uc_q_b | input | 16 | Quadrature sample of oscillator B (signed) |
| dac_offset | input | 16 | Offset stream, always added (signed) |
| dac_uc_i | input | 16 | Up-converter in-phase output (signed) |
| dac_partner_q | input | 16 | Partner channel quadrature output (signed) |
| en_wr | input | 1 | Write strobe for the enable register |
| en_data | input | 2 | Enable value: bit 0 in-phase, bit 1 partner quadrature |
| uc_lo_wr | input | 1 | Write strobe, up-converter lower bound |
| uc_lo_data | input | 16 | Up-converter lower bound value (signed) |
| uc_hi_wr | input | 1 | Write strobe, up-converter upper bound |
| uc_hi_data | input | 16 | Up-converter upper bound value (signed) |
| dac_lo_wr | input | 1 | Write strobe, DAC lower bound |
| dac_lo_data | input | 16 | DAC lower bound value (signed) |
| dac_hi_wr | input | 1 | Write strobe, DAC upper bound |
| dac_hi_data | input | 16 | DAC upper bound value (signed) |
| uc_i_out | output | 16 | Clamped in-phase up-converter input |
| uc_q_out | output | 16 | Clamped quadrature up-converter input |
| dac_out | output | 16 | Clamped DAC sample |

## Verification
The assertions run on every cycle and cover four properties. Each output stays inside bounds that are correctly ordered. Inverted bounds produce only one of the two bound values. No wrap occurs when a non-negative sum meets non-negative bounds. A bound or enable register moves only on its strobe, and takes exactly the strobed value. Some behaviours can only be shown by the bench's directed scenarios: the reset values, the numeric results of gated sums, the separation of the shared up-converter bounds from the DAC bounds, and the exact edge on which a write first applies.

// File: rtl/clampsum_pkg.sv
package clampsum_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int ACC_W      = 24;
  localparam int FULL_SCALE = 32767;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [ACC_W-1:0]    acc_t;

  typedef struct packed {
    sample_t lo;
    sample_t hi;
  } bounds_t;

  function automatic acc_t widen(input sample_t s);
    return {{(ACC_W-SAMPLE_W){s[SAMPLE_W-1]}}, s};
  endfunction

  function automatic logic above_hi(input acc_t v, input sample_t hi);
    return v > widen(hi);
  endfunction

  function automatic logic below_lo(input acc_t v, input sample_t lo);
    return v < widen(lo);
  endfunction

  // Upper comparison is evaluated first; it wins when bounds are inverted.
  function automatic sample_t clamp(input acc_t v, input bounds_t b);
    if (above_hi(v, b.hi))      return b.hi;
    else if (below_lo(v, b.lo)) return b.lo;
    else                        return v[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/bound_pair_reg.sv
module bound_pair_reg
  import clampsum_pkg::*;
#(
  parameter int RESET_HI = FULL_SCALE,
  parameter int RESET_LO = -FULL_SCALE
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lo_wr,
  input  sample_t lo_data,
  input  logic    hi_wr,
  input  sample_t hi_data,
  output bounds_t bounds
);
  localparam sample_t HI_INIT = sample_t'(RESET_HI);
  localparam sample_t LO_INIT = sample_t'(RESET_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bounds.hi <= HI_INIT;
      bounds.lo <= LO_INIT;
    end else begin
      if (hi_wr) bounds.hi <= hi_data;
      if (lo_wr) bounds.lo <= lo_data;
    end
  end

  // R8: a strobed value is held from the next edge on
  assert_hi_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> bounds.hi == $past(hi_data));
  assert_lo_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> bounds.lo == $past(lo_data));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_wr && !lo_wr) |=> $stable(bounds));
endmodule

// File: rtl/sat_junction.sv
module sat_junction
  import clampsum_pkg::*;
#(
  parameter int N_TERMS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_TERMS*SAMPLE_W-1:0] terms,
  input  logic [N_TERMS-1:0]          term_en,
  input  bounds_t                     bounds,
  output sample_t                     y
);
  localparam int SUM_W = SAMPLE_W + $clog2(N_TERMS) + 1;

  acc_t gated [N_TERMS];
  acc_t acc_sum;
  logic hit_hi;
  logic hit_lo;

  for (genvar g = 0; g < N_TERMS; g++) begin : g_term
    assign gated[g] = term_en[g] ? widen(terms[g*SAMPLE_W +: SAMPLE_W]) : '0;
  end

  always_comb begin
    acc_sum = '0;
    for (int k = 0; k < N_TERMS; k++) acc_sum = acc_sum + gated[k];
  end

  assign hit_hi = above_hi(acc_sum, bounds.hi);
  assign hit_lo = !hit_hi && below_lo(acc_sum, bounds.lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y <= '0;
    else        y <= clamp(acc_sum, bounds);
  end

  initial begin
    assert_acc_wide_R3: assert (SUM_W <= ACC_W);
  end

  // R1: ordered bounds contain the output
  assert_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(bounds.lo) <= $signed(bounds.hi)) |=>
      ($signed(y) <= $signed($past(bounds.hi)) && $signed(y) >= $signed($past(bounds.lo))));
  // R7: inverted bounds produce only a bound value, the upper one on overshoot
  assert_inverted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(bounds.lo) > $signed(bounds.hi)) |=>
      (y == $past(bounds.hi) || y == $past(bounds.lo)));
  assert_upper_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_hi |=> y == $past(bounds.hi));
  // R3: non-negative sum with non-negative ordered bounds never wraps negative
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sum >= 0 && !bounds.hi[SAMPLE_W-1] && !bounds.lo[SAMPLE_W-1]) |=>
      !y[SAMPLE_W-1]);
endmodule

// File: rtl/clamp_adder_bank.sv
module clamp_adder_bank
  import clampsum_pkg::*;
#(
  parameter logic [1:0] EN_RESET = 2'b01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] uc_i_a,
  input  logic [15:0] uc_i_b,
  input  logic [15:0] uc_q_a,
  input  logic [15:0] uc_q_b,
  input  logic [15:0] dac_offset,
  input  logic [15:0] dac_uc_i,
  input  logic [15:0] dac_partner_q,
  input  logic        en_wr,
  input  logic [1:0]  en_data,
  input  logic        uc_lo_wr,
  input  logic [15:0] uc_lo_data,
  input  logic        uc_hi_wr,
  input  logic [15:0] uc_hi_data,
  input  logic        dac_lo_wr,
  input  logic [15:0] dac_lo_data,
  input  logic        dac_hi_wr,
  input  logic [15:0] dac_hi_data,
  output logic [15:0] uc_i_out,
  output logic [15:0] uc_q_out,
  output logic [15:0] dac_out
);
  localparam int UC_TERMS  = 2;
  localparam int DAC_TERMS = 3;

  bounds_t    uc_bounds;
  bounds_t    dac_bounds;
  logic [1:0] en_cfg;
  logic       i_on;
  logic       q_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_cfg <= EN_RESET;
    else if (en_wr) en_cfg <= en_data;
  end
  assign i_on = en_cfg[0];
  assign q_on = en_cfg[1];

  // R5/R8: enable register changes only on its strobe
  assert_en_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_cfg));
  assert_en_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en_cfg == $past(en_data));

  bound_pair_reg u_uc_bounds (
    .clk, .rst_n,
    .lo_wr(uc_lo_wr), .lo_data(uc_lo_data),
    .hi_wr(uc_hi_wr), .hi_data(uc_hi_data),
    .bounds(uc_bounds)
  );

  bound_pair_reg u_dac_bounds (
    .clk, .rst_n,
    .lo_wr(dac_lo_wr), .lo_data(dac_lo_data),
    .hi_wr(dac_hi_wr), .hi_data(dac_hi_data),
    .bounds(dac_bounds)
  );

  sat_junction #(.N_TERMS(UC_TERMS)) u_jn_i (
    .clk, .rst_n,
    .terms({uc_i_b, uc_i_a}), .term_en('1),
    .bounds(uc_bounds), .y(uc_i_out)
  );

  sat_junction #(.N_TERMS(UC_TERMS)) u_jn_q (
    .clk, .rst_n,
    .terms({uc_q_b, uc_q_a}), .term_en('1),
    .bounds(uc_bounds), .y(uc_q_out)
  );

  sat_junction #(.N_TERMS(DAC_TERMS)) u_jn_dac (
    .clk, .rst_n,
    .terms({dac_partner_q, dac_uc_i, dac_offset}),
    .term_en({q_on, i_on, 1'b1}),
    .bounds(dac_bounds), .y(dac_out)
  );
endmodule

// File: tb/test_clamp_adder_bank.sv
module test_clamp_adder_bank;
  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] uc_i_a = 0, uc_i_b = 0, uc_q_a = 0, uc_q_b = 0;
  logic [15:0] dac_offset = 0, dac_uc_i = 0, dac_partner_q = 0;
  logic en_wr = 0;
  logic [1:0] en_data = 0;
  logic uc_lo_wr = 0, uc_hi_wr = 0, dac_lo_wr = 0, dac_hi_wr = 0;
  logic [15:0] uc_lo_data = 0, uc_hi_data = 0, dac_lo_data = 0, dac_hi_data = 0;
  logic [15:0] uc_i_out, uc_q_out, dac_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clamp_adder_bank i_clamp_adder_bank (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [15:0] act, int exp);
    checks++;
    if ($signed(act) !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, $signed(act), exp);
    end
  endtask

  // independent model: saturate an integer sum, upper test first
  function automatic int model(int s, int lo, int hi);
    int r;
    r = s;
    if (s > hi) r = hi;
    else if (s < lo) r = lo;
    return r;
  endfunction

  task automatic set_dac(int o, int i, int q);
    dac_offset = 16'(o); dac_uc_i = 16'(i); dac_partner_q = 16'(q);
  endtask

  task automatic write_en(logic [1:0] v);
    en_wr = 1; en_data = v; step(); en_wr = 0;
  endtask

  task automatic t_reset();
    chk("R9 reset uc_i", uc_i_out, 0);
    chk("R9 reset dac", dac_out, 0);
    uc_i_a = 16'(20000); uc_i_b = 16'(20000);
    uc_q_a = 16'(-20000); uc_q_b = 16'(-20000);
    set_dac(100, 200, 400);
    step();
    chk("R2 upper default", uc_i_out, 32767);
    chk("R2 lower default", uc_q_out, -32767);
    chk("R5 default enables", dac_out, 300);
  endtask

  task automatic t_enables();
    write_en(2'b10); step();
    chk("R4 q only", dac_out, 500);
    write_en(2'b11); step();
    chk("R4 both", dac_out, 700);
    write_en(2'b00); step();
    chk("R4 none", dac_out, 100);
    write_en(2'b11);
  endtask

  task automatic t_wide();
    set_dac(30000, 30000, -30000); step();
    chk("R3 no wrap", dac_out, 30000);
    set_dac(-30000, -30000, 25000); step();
    chk("R3 clamp not wrap", dac_out, model(-35000, -32767, 32767));
  endtask

  task automatic t_shared();
    uc_lo_wr = 1; uc_lo_data = 16'(-1000);
    uc_hi_wr = 1; uc_hi_data = 16'(1000);
    step(); uc_lo_wr = 0; uc_hi_wr = 0;
    uc_i_a = 16'(900); uc_i_b = 16'(900);
    uc_q_a = 16'(-900); uc_q_b = 16'(-900);
    set_dac(1000, 1000, 0);
    step();
    chk("R6 shared hi on I", uc_i_out, 1000);
    chk("R6 shared lo on Q", uc_q_out, -1000);
    chk("R6 DAC bounds separate", dac_out, 2000);
    uc_i_a = 16'(300); uc_i_b = 16'(-200); step();
    chk("R1 in range pass", uc_i_out, 100);
  endtask

  task automatic t_timing();
    set_dac(800, 0, 0);
    dac_hi_wr = 1; dac_hi_data = 16'(500);
    step(); dac_hi_wr = 0;
    chk("R8 same-edge sample uses old bound", dac_out, 800);
    step();
    chk("R8 next sample uses new bound", dac_out, 500);
    set_dac(-800, 0, 0);
    dac_lo_wr = 1; dac_lo_data = 16'(-300);
    step(); dac_lo_wr = 0;
    chk("R8 lower old", dac_out, -800);
    step();
    chk("R1 lower new", dac_out, -300);
  endtask

  task automatic t_inverted();
    dac_lo_wr = 1; dac_lo_data = 16'(100);
    dac_hi_wr = 1; dac_hi_data = 16'(-100);
    step(); dac_lo_wr = 0; dac_hi_wr = 0;
    set_dac(50, 0, 0); step();
    chk("R7 upper wins", dac_out, model(50, 100, -100));
    set_dac(-200, 0, 0); step();
    chk("R7 lower when not above", dac_out, model(-200, 100, -100));
  endtask

  task automatic t_latency();
    uc_i_a = 16'(7); uc_i_b = 16'(5);
    @(negedge clk);
    chk("R9 output unchanged before edge", uc_i_out, 100);
    step();
    chk("R9 one-cycle latency", uc_i_out, 12);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 in reset", uc_q_out, 0);
    rst_n = 1;
    step();
    t_reset();
    t_enables();
    t_wide();
    t_shared();
    t_timing();
    t_inverted();
    t_latency();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule